// File: doc/BRIEF.md
# Multi-format stereo audio serial transmitter

The block is the clock master and serializer of a stereo audio output link. It runs from the master clock and derives two clocks from it: a bit clock whose period is `MCLK_DIV` master-clock cycles, and a word clock that marks which channel is being sent and runs at the sample rate. Each frame holds two slots of `SLOT_W` bit clocks, the left slot first and then the right. A source hands over a left/right pair of two's-complement samples of `SAMPLE_W` bits through a valid/ready handshake. The block accepts a pair only at the frame boundary and shifts each sample out MSB first, with data changing on the falling edge of the bit clock.

A static format input chooses where the sample sits inside its slot. In I2S alignment the MSB follows the word-clock edge by one bit. In left alignment the MSB shares its bit with the word-clock edge. In right alignment the LSB fills the last bit of the slot. Slot bits that carry no sample bit are driven low. If no pair is offered when a frame starts, the previous pair is sent again and a one-cycle underrun pulse is raised.

The control is a four-state machine. `ST_IDLE` is the reset state and always moves to `ST_LOAD` (transition *start*). `ST_LOAD` takes the first pair and moves to `ST_BIT_LOW` (transition *launch*). `ST_BIT_LOW` holds the bit clock low for half a bit period and then moves to `ST_BIT_HIGH` (transition *rise*). `ST_BIT_HIGH` holds it high for the other half and then returns to `ST_BIT_LOW` on the next bit (transition *fall*). The *fall* transition out of the last bit of the frame also takes the next pair (transition *frame wrap*).

Top module: `audio_serial_tx`

## Requirements
- R1: `bclk` is low for `MCLK_DIV/2` master cycles and then high for `MCLK_DIV/2` master cycles, so its rising edges are exactly `MCLK_DIV` cycles apart.
- R2: `lrclk` is low during the left slot and high during the right slot. It changes only on a falling edge of `bclk`, and its falling edges are `2*SLOT_W*MCLK_DIV` master cycles apart.
- R3: With `fmt_sel` = 0 or 3 (I2S alignment), `lrclk` changes one bit before each slot begins, and the sample MSB is in the first bit of the slot, which is the bit after the `lrclk` edge.
- R4: With `fmt_sel` = 1 (left alignment), `lrclk` changes at the first bit of each slot, and the sample MSB is in that same bit.
- R5: With `fmt_sel` = 2 (right alignment), `lrclk` changes at the first bit of each slot. The sample occupies the last `SAMPLE_W` bits of the slot, MSB first, with its LSB in the last bit.
- R6: Every slot bit that carries no sample bit is driven to 0.
- R7: `sdata` changes only on a falling edge of `bclk`, apart from the first data bit after reset.
- R8: `s_ready` is a single-cycle pulse. It is raised in the cycle that ends the last bit of a frame, and once in `ST_LOAD` after reset. The pair presented in that cycle is sent in the frame that follows, and the held pair does not change at any other time.
- R9: If `s_valid` is low while `s_ready` is high, the previous pair is sent again in the next frame and `underrun` is high for exactly the next cycle. Otherwise `underrun` stays low.
- R10: While reset is asserted, `bclk`, `lrclk`, `sdata`, `s_ready` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Alignment: 0 I2S, 1 left, 2 right, 3 I2S; held static |
| s_valid | input | 1 | A sample pair is offered |
| s_ready | output | 1 | Pair accepted in this cycle if `s_valid` is high |
| s_left | input | SAMPLE_W | Left-channel sample, two's complement |
| s_right | input | SAMPLE_W | Right-channel sample, two's complement |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word clock: low for left, high for right |
| sdata | output | 1 | Serial data, MSB first |
| underrun | output | 1 | One-cycle pulse when a frame repeats the previous pair |

## Verification
The bench builds the block with `SAMPLE_W` = 20, `SLOT_W` = 32 and `MCLK_DIV` = 4. Because the sample is narrower than the slot, all three alignments leave visible padding, so the MSB position and the zero padding at both ends of the slot (R3 to R6) can be told apart. A four-cycle bit period puts two master cycles in each bit-clock phase, which lets the bench see that the ready pulse falls on the last cycle of the frame and not on the bit edge. All four `fmt_sel` codes are run in turn, with a reset between them, and each run includes a frame in which no pair is offered.

// File: rtl/asx_pkg.sv
package asx_pkg;

    // alignment codes seen on fmt_sel
    localparam logic [1:0] FMT_I2S     = 2'd0;
    localparam logic [1:0] FMT_LEFT    = 2'd1;
    localparam logic [1:0] FMT_RIGHT   = 2'd2;
    localparam logic [1:0] FMT_I2S_ALT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOAD     = 2'd1,
        ST_BIT_LOW  = 2'd2,
        ST_BIT_HIGH = 2'd3
    } asx_state_e;

endpackage

// File: rtl/asx_pair_hold.sv
module asx_pair_hold #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                valid_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                underrun_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_o     <= '0;
            right_o    <= '0;
            underrun_o <= 1'b0;
        end else begin
            underrun_o <= load_i && !valid_i;
            if (load_i && valid_i) begin
                left_o  <= left_i;
                right_o <= right_i;
            end
        end
    end

    // R8: the held pair moves only at an accepted frame boundary
    p_hold_only_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/asx_slot_map.sv
module asx_slot_map #(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 32,
    parameter int POS_W    = 6
) (
    input  logic [1:0]          fmt_i,
    input  logic                active_i,
    input  logic [POS_W-1:0]    pos_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                sdata_o,
    output logic                lrclk_o
);
    import asx_pkg::*;

    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int PAD_W      = SLOT_W - SAMPLE_W;

    always_comb begin
        int                  p;
        int                  q;
        int                  idx;
        logic                in_right;
        logic [SAMPLE_W-1:0] smp;
        logic                bit_v;

        p        = int'(pos_i);
        in_right = (p >= SLOT_W);
        q        = in_right ? (p - SLOT_W) : p;
        smp      = in_right ? right_i : left_i;
        idx      = -1;
        lrclk_o  = in_right;

        unique case (fmt_i)
            FMT_RIGHT: begin
                if (q >= PAD_W) idx = SLOT_W - 1 - q;
            end
            FMT_LEFT: begin
                if (q < SAMPLE_W) idx = SAMPLE_W - 1 - q;
            end
            FMT_I2S, FMT_I2S_ALT: begin
                if (q < SAMPLE_W) idx = SAMPLE_W - 1 - q;
                // word clock leads the slot by one bit
                lrclk_o = (((p + 1) % FRAME_BITS) >= SLOT_W);
            end
            default: ;
        endcase

        bit_v = 1'b0;
        for (int k = 0; k < SAMPLE_W; k++) begin
            if (k == idx) bit_v = smp[k];
        end
        sdata_o = bit_v && active_i;
    end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
    import asx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 32,
    parameter int MCLK_DIV = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt_sel,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                bclk,
    output logic                lrclk,
    output logic                sdata,
    output logic                underrun
);

    localparam int HALF       = MCLK_DIV / 2;
    localparam int HALF_CW    = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int BIT_CW     = $clog2(FRAME_BITS);

    asx_state_e          state_q, state_d;
    logic [HALF_CW-1:0]  half_q, half_d;
    logic [BIT_CW-1:0]   bit_q, bit_d;
    logic                half_last, bit_last, frame_end, load, active;
    logic [SAMPLE_W-1:0] held_left, held_right;

    assign half_last = (half_q == HALF_CW'(HALF - 1));
    assign bit_last  = (bit_q == BIT_CW'(FRAME_BITS - 1));

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        half_d  = half_q;
        bit_d   = bit_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_LOAD;                 // start
            ST_LOAD: begin                              // launch
                state_d = ST_BIT_LOW;
                half_d  = '0;
                bit_d   = '0;
            end
            ST_BIT_LOW: begin
                if (half_last) begin                    // rise
                    state_d = ST_BIT_HIGH;
                    half_d  = '0;
                end else begin
                    half_d  = half_q + 1'b1;
                end
            end
            ST_BIT_HIGH: begin
                if (half_last) begin                    // fall / frame wrap
                    state_d = ST_BIT_LOW;
                    half_d  = '0;
                    bit_d   = bit_last ? '0 : bit_q + 1'b1;
                end else begin
                    half_d  = half_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
            bit_q   <= bit_d;
        end
    end

    // outputs decoded from the state
    always_comb begin
        frame_end = (state_q == ST_BIT_HIGH) && half_last && bit_last;
        load      = (state_q == ST_LOAD) || frame_end;
        active    = (state_q == ST_BIT_LOW) || (state_q == ST_BIT_HIGH);
        bclk      = (state_q == ST_BIT_HIGH);
        s_ready   = load;
    end

    asx_pair_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .valid_i    (s_valid),
        .left_i     (s_left),
        .right_i    (s_right),
        .left_o     (held_left),
        .right_o    (held_right),
        .underrun_o (underrun)
    );

    asx_slot_map #(
        .SAMPLE_W (SAMPLE_W),
        .SLOT_W   (SLOT_W),
        .POS_W    (BIT_CW)
    ) u_map (
        .fmt_i    (fmt_sel),
        .active_i (active),
        .pos_i    (bit_q),
        .left_i   (held_left),
        .right_i  (held_right),
        .sdata_o  (sdata),
        .lrclk_o  (lrclk)
    );

    // R8: ready never lasts two cycles
    p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // R7: data moves with the falling bit clock (first launch excepted)
    p_sdata_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(bclk) && $past(state_q) != ST_LOAD) |-> $stable(sdata));

    // R2: word clock moves only with the falling bit clock
    p_lrclk_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk) |-> $fell(bclk));

    // R9: an underrun follows a boundary that found no pair
    p_underrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(s_ready && !s_valid));

endmodule

// File: tb/audio_serial_tx_tb.sv
module audio_serial_tx_tb;

    localparam int SW  = 20;
    localparam int SL  = 32;
    localparam int DIV = 4;
    localparam int FB  = 2 * SL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    fmt_sel = 2'd0;
    logic          s_valid = 1'b0;
    logic [SW-1:0] s_left = '0;
    logic [SW-1:0] s_right = '0;
    logic          s_ready, bclk, lrclk, sdata, underrun;

    always #2 clk = ~clk;   // 250 MHz

    audio_serial_tx #(.SAMPLE_W(SW), .SLOT_W(SL), .MCLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .s_valid(s_valid), .s_ready(s_ready),
        .s_left(s_left), .s_right(s_right),
        .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .underrun(underrun)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard queue of pairs expected on the line
    logic [2*SW-1:0] exp_q[$];
    logic [2*SW-1:0] last_pair;
    bit              ur_due;
    int              frames_seen;

    // handshake watcher: builds expectations (R8, R9)
    always @(negedge clk) begin
        if (!rst_n) begin
            last_pair = '0;
            ur_due    = 1'b0;
        end else begin
            if (ur_due || underrun)
                check(underrun == ur_due, "R9", "underrun pulse", underrun, ur_due);
            ur_due = 1'b0;
            if (s_ready) begin
                if (s_valid) last_pair = {s_left, s_right};
                else ur_due = 1'b1;   // R9: previous pair repeats
                exp_q.push_back(last_pair);
            end
        end
    end

    // monitor: deserializes and compares
    bit     prev_bclk, prev_lr, synced;
    int     pos, cyc, last_rise, last_fall;
    bit     fr[FB];

    function automatic bit is_i2s();
        return (fmt_sel == 2'd0) || (fmt_sel == 2'd3);
    endfunction

    task automatic compare_frame();
        logic [2*SW-1:0] e;
        string           req;
        req = is_i2s() ? "R3" : (fmt_sel == 2'd1) ? "R4" : "R5";
        if (exp_q.size() == 0) begin
            check(0, "R8", "no expected pair", 0, 1);
            return;
        end
        e = exp_q.pop_front();
        frames_seen++;
        for (int ch = 0; ch < 2; ch++) begin
            logic [SW-1:0] got, want;
            int            pad_ones;
            int            base;
            base     = ch * SL;
            pad_ones = 0;
            want     = (ch == 0) ? e[2*SW-1:SW] : e[SW-1:0];
            for (int k = 0; k < SW; k++) begin
                if (fmt_sel == 2'd2) got[SW-1-k] = fr[base + SL - SW + k];
                else                 got[SW-1-k] = fr[base + k];
            end
            for (int k = 0; k < SL - SW; k++) begin
                if (fmt_sel == 2'd2) pad_ones += int'(fr[base + k]);
                else                 pad_ones += int'(fr[base + SW + k]);
            end
            check(got == want, req, ch == 0 ? "left sample" : "right sample",
                  got, want);
            check(pad_ones == 0, "R6", "padding ones", pad_ones, 0);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_bclk = 1'b0; prev_lr = 1'b0; synced = 1'b0;
            pos = 0; cyc = 0; last_rise = -1; last_fall = -1;
        end else begin
            cyc++;
            if (bclk && !prev_bclk) begin
                if (last_rise >= 0)
                    check(cyc - last_rise == DIV, "R1", "bclk period",
                          cyc - last_rise, DIV);
                last_rise = cyc;
                if (prev_lr && !lrclk) begin
                    if (last_fall >= 0)
                        check(cyc - last_fall == FB * DIV, "R2", "lrclk period",
                              cyc - last_fall, FB * DIV);
                    last_fall = cyc;
                    if (!synced) begin
                        synced = 1'b1;
                        pos    = is_i2s() ? -1 : 0;
                        if (exp_q.size() > 0) void'(exp_q.pop_front());
                    end
                end
                if (synced) begin
                    bit exp_lr;
                    exp_lr = is_i2s() ? (((pos + 1) % FB) >= SL) : (pos >= SL);
                    check(lrclk == exp_lr, is_i2s() ? "R3" : "R2",
                          "lrclk level", lrclk, exp_lr);
                    if (pos >= 0) fr[pos] = sdata;
                    if (pos == FB - 1) begin
                        compare_frame();
                        pos = 0;
                    end else begin
                        pos++;
                    end
                end
                prev_lr = lrclk;
            end
            prev_bclk = bclk;
        end
    end

    // driver
    task automatic drive_pair(input logic [SW-1:0] l, input logic [SW-1:0] r);
        @(posedge clk);
        #1;
        s_valid = 1'b1; s_left = l; s_right = r;
        do @(negedge clk); while (!s_ready);
        @(posedge clk);
        #1;
        s_valid = 1'b0;
    endtask

    task automatic skip_boundary();
        do @(negedge clk); while (!s_ready);
    endtask

    task automatic run_phase(input int m);
        int start_frames;
        rst_n = 1'b0;
        fmt_sel = 2'(m);
        s_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: quiet outputs in reset
        check({bclk, lrclk, sdata, s_ready, underrun} == 5'b0, "R10",
              "reset outputs", {bclk, lrclk, sdata, s_ready, underrun}, 0);
        exp_q.delete();
        start_frames = frames_seen;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++)
            drive_pair(SW'($urandom), SW'($urandom));
        drive_pair({1'b1, {(SW-1){1'b0}}}, SW'(1));   // MSB-only and LSB-only
        skip_boundary();                              // R9 repeat frame
        drive_pair({SW{1'b1}}, {1'b0, {(SW-1){1'b1}}});
        drive_pair(SW'($urandom), SW'($urandom));
        repeat (3 * FB * DIV) @(posedge clk);
        check(frames_seen - start_frames >= 8, "R8", "frames decoded",
              frames_seen - start_frames, 8);
    endtask

    initial begin
        frames_seen = 0;
        for (int m = 0; m < 4; m++) run_phase(m);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule